// File: doc/BRIEF.md
# SDRAM Controller with Power-Up Sequence and Auto Refresh

This block drives a single SDR SDRAM device with four banks, 12-bit row addresses and 10-bit column addresses from a 100 MHz clock. A client presents one access at a time: a read or write flag, bank, row, column, write data and byte enables, under a valid/ready handshake. The controller opens the row, issues the column command with auto precharge, and for reads returns the captured word on a one-cycle response strobe once the CAS latency has elapsed. Every access is a single word, so a page is never left open.

After reset the controller keeps the device clock enabled and sends no-ops for a parameterised settling time. It then closes all banks, runs two refresh cycles and loads the mode register, and only after that does it accept requests. From then on a refresh timer raises a request at a fixed interval. The refresh is issued as soon as the access in flight has finished, ahead of any waiting client request. All spacing rules are held as whole clock counts in parameters, and one down-counter enforces them.

Top module: `sdram_ctrl`

## Requirements
- R1: While rst_ni is low, sd_cke_o is 0, the command pins {cs,ras,cas,we} are 4'b1111 (deselect) and req_ready_o is 0.
- R2: After reset, exactly INIT_WAIT cycles of no-op (4'b0111) with CKE high precede the first command. The start-up commands are then issued in this order: precharge with A10=1, refresh, refresh, mode load. req_ready_o stays 0 until the mode load has been issued.
- R3: The mode load drives bank 0 and the address word {A11..A10=00, A9=0, A8..A7=00, A6..A4=CAS code, A3=0, A2..A0=000}, so burst length is 1 and burst order is sequential. The CAS code is 010 for latency 2 and 011 for latency 3, which makes the word 12'h030 at latency 3.
- R4: Command codes on {cs,ras,cas,we}: mode load 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, no-op 0111. No other code appears after reset.
- R5: Row activate to read/write is at least T_RCD cycles. Activate to activate is at least T_RC. A refresh is followed by at least T_RC cycles before the next command, a precharge by at least T_RP, and a mode load by at least T_MRD.
- R6: Read and write commands carry A10=1 (auto precharge) and the column on A9..A0. The next activate after a write comes at least T_RDL+T_RP cycles after that write.
- R7: On a write cycle sd_dq_o carries the request data, sd_dq_oe_o is 1 and sd_dqm_o is the inverse of the byte enables (1 = byte masked). On a read cycle sd_dqm_o is 0. sd_dq_oe_o is 0 on every cycle that is not a write.
- R8: rsp_valid_o is high for exactly one cycle, CAS_LAT+1 cycles after the cycle in which the read command is on the pins. rsp_rdata_o holds the word sampled from sd_dq_i at the clock edge that raises rsp_valid_o.
- R9: The clock edge where req_valid_i and req_ready_o are both high accepts a request. req_ready_o is low in the next cycle and stays low for at least T_RCD+POST-1 cycles, where POST = max(T_RC-T_RCD, T_RDL+T_RP, CAS_LAT+2).
- R10: After start-up, a refresh is issued at most REFRESH_INTERVAL+T_RCD+POST+1 cycles after the previous refresh (or after the mode load). A pending refresh is issued before a waiting request, and a refresh request is never lost.
- R11: A read returns, for each byte, the data of the last write to the same bank, row and column whose enable for that byte was 1. Bytes whose enable was 0 keep their older value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | BANK_W | Bank |
| req_row_i | input | ROW_W | Row |
| req_col_i | input | COL_W | Column |
| req_wdata_i | input | DW | Write data |
| req_be_i | input | DW/8 | Byte enables, 1 = write byte |
| rsp_valid_o | output | 1 | Read data valid strobe |
| rsp_rdata_o | output | DW | Read data |
| sd_cke_o | output | 1 | Device clock enable |
| sd_cs_no | output | 1 | Chip select, active low |
| sd_ras_no | output | 1 | Row strobe, active low |
| sd_cas_no | output | 1 | Column strobe, active low |
| sd_we_no | output | 1 | Write enable, active low |
| sd_ba_o | output | BANK_W | Bank address |
| sd_addr_o | output | ROW_W | Multiplexed address |
| sd_dqm_o | output | DW/8 | Byte mask |
| sd_dq_o | output | DW | Write data to device |
| sd_dq_oe_o | output | 1 | Drive enable for data pins |
| sd_dq_i | input | DW | Read data from device |

## Verification
The bench builds the controller with CAS_LAT=3, INIT_WAIT=50 and REFRESH_INTERVAL=60, and keeps the 10 ns timing counts. The short settling time makes the whole start-up sequence cheap to observe. The short refresh period makes refreshes collide with a continuous stream of requests many times, so the priority and the worst-case refresh spacing are both exercised. The CAS latency of 3 sets the read-latency check and the expected mode word. A bench-side device model resolves bank, row and column from the command stream, so byte-masked writes, bank separation and boundary addresses are checked against data.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_ACT   = 4'b0011,
    CMD_WR    = 4'b0100,
    CMD_RD    = 4'b0101,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_REF1,
    ST_REF2,
    ST_MRS,
    ST_IDLE,
    ST_RW
  } ctrl_st_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int INTERVAL = 1562
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ack_i,
  output logic pend_o
);
  localparam int W = $clog2(INTERVAL + 1);

  logic [W-1:0] cnt_q;
  logic         tick;

  assign tick = en_i && (cnt_q == W'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      if (!en_i || tick) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
      if (tick)       pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
    end
  end

  AST_ACK_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> pend_o);                                   // R10
  AST_NO_LOST_REFRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> (!pend_o || ack_i));                        // R10

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int CAS_LAT = 2,
  parameter int DW      = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic [DW-1:0] dq_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  // bit k set k+1 edges after the read left the controller
  logic [CAS_LAT:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      sh_q    <= {sh_q[CAS_LAT-1:0], issue_i};
      valid_o <= sh_q[CAS_LAT];
      if (sh_q[CAS_LAT]) data_o <= dq_i;
    end
  end

  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);                               // R8

endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int DW               = 16,
  parameter int BANK_W           = 2,
  parameter int ROW_W            = 12,
  parameter int COL_W            = 10,
  parameter int CAS_LAT          = 2,
  parameter int INIT_WAIT        = 20000,
  parameter int REFRESH_INTERVAL = 1562,
  parameter int T_RCD            = 2,
  parameter int T_RP             = 2,
  parameter int T_RC             = 7,
  parameter int T_RDL            = 2,
  parameter int T_MRD            = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [DW/8-1:0]   req_be_i,
  output logic              rsp_valid_o,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic              sd_cke_o,
  output logic              sd_cs_no,
  output logic              sd_ras_no,
  output logic              sd_cas_no,
  output logic              sd_we_no,
  output logic [BANK_W-1:0] sd_ba_o,
  output logic [ROW_W-1:0]  sd_addr_o,
  output logic [DW/8-1:0]   sd_dqm_o,
  output logic [DW-1:0]     sd_dq_o,
  output logic              sd_dq_oe_o,
  input  logic [DW-1:0]     sd_dq_i
);
  localparam int BE_W    = DW / 8;
  localparam int AP_BIT  = 10;
  localparam int POST_RW = imax(imax(T_RC - T_RCD, T_RDL + T_RP), CAS_LAT + 2);
  localparam int CNT_W   = $clog2(INIT_WAIT + T_RC + POST_RW + 2);
  localparam int GAP_W   = $clog2(T_RC + T_RP + T_MRD + 1) + 1;
  localparam logic [2:0] CL_CODE = (CAS_LAT == 3) ? 3'b011 : 3'b010;
  localparam logic [ROW_W-1:0] MODE_WORD =
    ROW_W'({2'b00, 1'b0, 2'b00, CL_CODE, 1'b0, 3'b000});
  localparam logic [ROW_W-1:0] AP_MASK = ROW_W'(1) << AP_BIT;

  ctrl_st_e          st_q;
  sd_cmd_e           cmd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cke_q, oe_q, init_done_q;
  logic [BANK_W-1:0] ba_q;
  logic [ROW_W-1:0]  addr_q;
  logic [BE_W-1:0]   dqm_q;
  logic [DW-1:0]     dq_q;
  logic              wr_q;
  logic [COL_W-1:0]  col_q;
  logic [DW-1:0]     wd_q;
  logic [BE_W-1:0]   be_q;
  logic              ref_pend, ref_ack, rd_issue, slot_free;
  logic [ROW_W-1:0]  rw_addr;

  assign slot_free   = (st_q == ST_IDLE) && (cnt_q == '0);
  assign ref_ack     = slot_free && ref_pend;
  assign req_ready_o = slot_free && !ref_pend;
  assign rd_issue    = (st_q == ST_RW) && (cnt_q == '0) && !wr_q;

  always_comb begin
    rw_addr = AP_MASK;
    rw_addr[COL_W-1:0] = col_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_PWR;
      cnt_q       <= CNT_W'(INIT_WAIT);
      cmd_q       <= CMD_DESEL;
      cke_q       <= 1'b0;
      oe_q        <= 1'b0;
      init_done_q <= 1'b0;
      ba_q        <= '0;
      addr_q      <= '0;
      dqm_q       <= '0;
      dq_q        <= '0;
      wr_q        <= 1'b0;
      col_q       <= '0;
      wd_q        <= '0;
      be_q        <= '0;
    end else begin
      cke_q <= 1'b1;
      cmd_q <= CMD_NOP;
      oe_q  <= 1'b0;
      dqm_q <= '0;
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        unique case (st_q)
          ST_PWR: begin
            cmd_q  <= CMD_PRE;
            addr_q <= AP_MASK;
            cnt_q  <= CNT_W'(T_RP - 1);
            st_q   <= ST_REF1;
          end
          ST_REF1: begin
            cmd_q <= CMD_REF;
            cnt_q <= CNT_W'(T_RC - 1);
            st_q  <= ST_REF2;
          end
          ST_REF2: begin
            cmd_q <= CMD_REF;
            cnt_q <= CNT_W'(T_RC - 1);
            st_q  <= ST_MRS;
          end
          ST_MRS: begin
            cmd_q       <= CMD_MRS;
            ba_q        <= '0;
            addr_q      <= MODE_WORD;
            cnt_q       <= CNT_W'(T_MRD - 1);
            st_q        <= ST_IDLE;
            init_done_q <= 1'b1;
          end
          ST_IDLE: begin
            if (ref_pend) begin
              cmd_q <= CMD_REF;
              cnt_q <= CNT_W'(T_RC - 1);
            end else if (req_valid_i) begin
              cmd_q  <= CMD_ACT;
              ba_q   <= req_bank_i;
              addr_q <= req_row_i;
              wr_q   <= req_write_i;
              col_q  <= req_col_i;
              wd_q   <= req_wdata_i;
              be_q   <= req_be_i;
              cnt_q  <= CNT_W'(T_RCD - 1);
              st_q   <= ST_RW;
            end
          end
          ST_RW: begin
            cmd_q  <= wr_q ? CMD_WR : CMD_RD;
            addr_q <= rw_addr;
            dqm_q  <= wr_q ? ~be_q : '0;
            dq_q   <= wd_q;
            oe_q   <= wr_q;
            cnt_q  <= CNT_W'(POST_RW - 1);
            st_q   <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  sdram_refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) u_refresh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (init_done_q),
    .ack_i  (ref_ack),
    .pend_o (ref_pend)
  );

  sdram_rd_pipe #(.CAS_LAT(CAS_LAT), .DW(DW)) u_rd_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (rd_issue),
    .dq_i    (sd_dq_i),
    .valid_o (rsp_valid_o),
    .data_o  (rsp_rdata_o)
  );

  assign {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no} = cmd_q;
  assign sd_cke_o   = cke_q;
  assign sd_ba_o    = ba_q;
  assign sd_addr_o  = addr_q;
  assign sd_dqm_o   = dqm_q;
  assign sd_dq_o    = dq_q;
  assign sd_dq_oe_o = oe_q;

  // spacing monitors for the timing assertions
  logic [GAP_W-1:0] gap_act_q, gap_cmd_q;
  sd_cmd_e          last_q;
  logic             is_cmd;

  assign is_cmd = (cmd_q != CMD_NOP) && (cmd_q != CMD_DESEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_act_q <= '1;
      gap_cmd_q <= '1;
      last_q    <= CMD_NOP;
    end else begin
      if (cmd_q == CMD_ACT)   gap_act_q <= GAP_W'(1);
      else if (gap_act_q != '1) gap_act_q <= gap_act_q + 1'b1;
      if (is_cmd) begin
        gap_cmd_q <= GAP_W'(1);
        last_q    <= cmd_q;
      end else if (gap_cmd_q != '1) begin
        gap_cmd_q <= gap_cmd_q + 1'b1;
      end
    end
  end

  AST_RCD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> gap_act_q >= GAP_W'(T_RCD));   // R5
  AST_RC_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_ACT) |-> gap_act_q >= GAP_W'(T_RC));                      // R5
  AST_MRD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd && last_q == CMD_MRS) |-> gap_cmd_q >= GAP_W'(T_MRD));          // R5
  AST_REF_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd && last_q == CMD_REF) |-> gap_cmd_q >= GAP_W'(T_RC));           // R5
  AST_ACCEPT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);                         // R9
  AST_READY_AFTER_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> init_done_q);                                           // R2

endmodule

// File: tb/sim_sdram_ctrl.sv
module sim_sdram_ctrl;
  localparam int CLK_NS    = 10;
  localparam int DW        = 16;
  localparam int CL        = 3;
  localparam int INIT_WAIT = 50;
  localparam int REF_INT   = 60;
  localparam int T_RCD = 2, T_RP = 2, T_RC = 7, T_RDL = 2, T_MRD = 2;
  localparam int POST    = 5;  // max(T_RC-T_RCD, T_RDL+T_RP, CL+2)
  localparam int REF_MAX = REF_INT + T_RCD + POST + 1;

  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
    C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111, C_DES = 4'b1111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [1:0] req_bank = '0, req_be = '0;
  logic [11:0] req_row = '0;
  logic [9:0] req_col = '0;
  logic [15:0] req_wdata = '0;
  logic rsp_valid, cke, cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [15:0] rsp_rdata, dq_out, dq_in = '0;
  logic [1:0] ba, dqm;
  logic [11:0] addr;
  logic [3:0] cmd;

  always #(CLK_NS/2) clk = ~clk;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  sdram_ctrl #(.DW(DW), .CAS_LAT(CL), .INIT_WAIT(INIT_WAIT), .REFRESH_INTERVAL(REF_INT),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_RDL(T_RDL), .T_MRD(T_MRD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .req_wdata_i(req_wdata), .req_be_i(req_be), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .sd_cke_o(cke), .sd_cs_no(cs_n), .sd_ras_no(ras_n), .sd_cas_no(cas_n), .sd_we_no(we_n),
    .sd_ba_o(ba), .sd_addr_o(addr), .sd_dqm_o(dqm), .sd_dq_o(dq_out), .sd_dq_oe_o(dq_oe),
    .sd_dq_i(dq_in));

  int nchk = 0, nbad = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard state
  logic [15:0] shadow [int];
  logic [15:0] mem [int];
  logic [15:0] exp_q [$];
  logic [17:0] wr_exp_q [$];
  int rd_t_q [$];
  int due_q [$];
  logic [15:0] due_d_q [$];
  logic [11:0] act_row [4];

  int cyc = 0, last_act = -1000, last_wr = -1000, last_cyc = -1000, last_ref = 0;
  int init_idx = 0, nop_cnt = 0, nref = 0;
  bit mrs_seen = 1'b0;
  logic [3:0] last_cmd = C_NOP;

  function automatic int key(input logic [1:0] b, input logic [11:0] r, input logic [9:0] c);
    return int'({b, r, c});
  endfunction

  // device model and command monitor
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        void'(due_q.pop_front());
        dq_in = due_d_q.pop_front();
      end
      if (!mrs_seen) begin
        if (req_ready) chk(1'b0, "R2", "ready before mode load", 1, 0);
        if (init_idx == 0 && cmd == C_NOP && cke) nop_cnt++;
      end
      if (dq_oe && cmd != C_WR) chk(1'b0, "R7", "data driven off write", cmd, C_WR);
      if (cmd != C_NOP && cmd != C_DES) begin
        if (last_cmd == C_MRS) chk(cyc - last_cyc >= T_MRD, "R5", "mode load gap", cyc - last_cyc, T_MRD);
        if (last_cmd == C_REF) chk(cyc - last_cyc >= T_RC, "R5", "refresh gap", cyc - last_cyc, T_RC);
        if (last_cmd == C_PRE) chk(cyc - last_cyc >= T_RP, "R5", "precharge gap", cyc - last_cyc, T_RP);
        case (cmd)
          C_PRE: begin
            chk(init_idx == 0, "R2", "precharge position", init_idx, 0);
            chk(addr[10], "R2", "precharge-all A10", addr[10], 1);
            chk(nop_cnt == INIT_WAIT, "R2", "power-up no-op count", nop_cnt, INIT_WAIT);
          end
          C_REF: begin
            if (mrs_seen) begin
              chk(cyc - last_ref <= REF_MAX, "R10", "refresh spacing", cyc - last_ref, REF_MAX);
              last_ref = cyc;
              nref++;
            end else begin
              chk(init_idx == 1 || init_idx == 2, "R2", "refresh position", init_idx, 1);
            end
          end
          C_MRS: begin
            chk(init_idx == 3, "R2", "mode load position", init_idx, 3);
            chk(addr == 12'h030, "R3", "mode word", addr, 12'h030);
            chk(ba == 2'b00, "R3", "mode bank", ba, 0);
            mrs_seen = 1'b1;
            last_ref = cyc;
          end
          C_ACT: begin
            chk(mrs_seen, "R2", "activate before init", 0, 1);
            chk(cyc - last_act >= T_RC, "R5", "activate spacing", cyc - last_act, T_RC);
            chk(cyc - last_wr >= T_RDL + T_RP, "R6", "write recovery", cyc - last_wr, T_RDL + T_RP);
            act_row[ba] = addr;
            last_act = cyc;
          end
          C_RD: begin
            chk(cyc - last_act >= T_RCD, "R5", "read after activate", cyc - last_act, T_RCD);
            chk(addr[10], "R6", "read auto precharge", addr[10], 1);
            chk(dqm == 2'b00, "R7", "read mask", dqm, 0);
            due_q.push_back(cyc + CL);
            due_d_q.push_back(mem[key(ba, act_row[ba], addr[9:0])]);
            rd_t_q.push_back(cyc);
          end
          C_WR: begin
            logic [17:0] w;
            chk(cyc - last_act >= T_RCD, "R5", "write after activate", cyc - last_act, T_RCD);
            chk(addr[10], "R6", "write auto precharge", addr[10], 1);
            w = wr_exp_q.pop_front();
            chk(dq_out == w[15:0], "R7", "write data", dq_out, w[15:0]);
            chk(dqm == ~w[17:16], "R7", "write mask", dqm, ~w[17:16]);
            chk(dq_oe, "R7", "write drive", dq_oe, 1);
            begin
              int k;
              logic [15:0] m;
              k = key(ba, act_row[ba], addr[9:0]);
              m = mem.exists(k) ? mem[k] : 16'h0;
              if (!dqm[0]) m[7:0]  = dq_out[7:0];
              if (!dqm[1]) m[15:8] = dq_out[15:8];
              mem[k] = m;
            end
            last_wr = cyc;
          end
          default: chk(1'b0, "R4", "unexpected command", cmd, C_NOP);
        endcase
        if (!mrs_seen || cmd == C_MRS) init_idx++;
        last_cmd = cmd;
        last_cyc = cyc;
      end
      if (rsp_valid) begin
        int t;
        logic [15:0] e;
        t = rd_t_q.pop_front();
        chk(cyc - t == CL + 1, "R8", "read latency", cyc - t, CL + 1);
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R11", "read data", rsp_rdata, e);
      end
    end
  end

  // driver: one access, pushes the expected outcome
  task automatic access(input bit wr, input logic [1:0] b, input logic [11:0] r,
                        input logic [9:0] c, input logic [15:0] d, input logic [1:0] be);
    int k, n;
    logic [15:0] s;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_bank = b; req_row = r;
    req_col = c; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    k = key(b, r, c);
    s = shadow.exists(k) ? shadow[k] : 16'h0;
    if (wr) begin
      if (be[0]) s[7:0]  = d[7:0];
      if (be[1]) s[15:8] = d[15:8];
      shadow[k] = s;
      wr_exp_q.push_back({be, d});
    end else begin
      exp_q.push_back(s);
    end
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!req_ready) begin
      n++;
      @(negedge clk);
    end
    chk(n >= T_RCD + POST - 1, "R9", "ready low window", n, T_RCD + POST - 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(cke == 1'b0, "R1", "cke in reset", cke, 0);
    chk(cmd == C_DES, "R1", "command in reset", cmd, C_DES);
    chk(req_ready == 1'b0, "R1", "ready in reset", req_ready, 0);
    rst_n = 1'b1;

    access(1, 2'd0, 12'h005, 10'h003, 16'hA5A5, 2'b11);
    access(0, 2'd0, 12'h005, 10'h003, 16'h0, 2'b00);
    access(1, 2'd3, 12'hFFF, 10'h3FF, 16'h1234, 2'b11);
    access(1, 2'd1, 12'h005, 10'h003, 16'h5A5A, 2'b11);
    access(0, 2'd3, 12'hFFF, 10'h3FF, 16'h0, 2'b00);
    access(0, 2'd0, 12'h005, 10'h003, 16'h0, 2'b00);
    // byte enables: low only, high only, none
    access(1, 2'd0, 12'h005, 10'h003, 16'hFF00, 2'b01);
    access(0, 2'd0, 12'h005, 10'h003, 16'h0, 2'b00);
    access(1, 2'd0, 12'h005, 10'h003, 16'h77EE, 2'b10);
    access(1, 2'd0, 12'h005, 10'h003, 16'hDEAD, 2'b00);
    access(0, 2'd0, 12'h005, 10'h003, 16'h0, 2'b00);
    access(0, 2'd1, 12'h005, 10'h003, 16'h0, 2'b00);
    // continuous stream across many refresh periods
    for (int i = 0; i < 40; i++) begin
      access(1, 2'(i), 12'(i * 37), 10'(i * 19), 16'(i * 16'h0101 + 16'h3C), 2'b11);
      access(0, 2'(i), 12'(i * 37), 10'(i * 19), 16'h0, 2'b00);
    end
    begin
      int r0;
      r0 = nref;
      repeat (300) @(negedge clk);
      chk(nref - r0 >= 300 / REF_MAX, "R10", "idle refresh count", nref - r0, 300 / REF_MAX);
    end
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "responses outstanding", exp_q.size(), 0);
    chk(nref > 8, "R10", "refreshes during traffic", nref, 9);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule